// File: doc/BRIEF.md
# Task-Owned Shared Multiplier Gate

This block puts an ownership gate in front of a single iterative 32x32 unsigned multiplier. Four hardware tasks share the multiplier, and they issue in interleaved clock slots on one core. Each request carries the 2-bit ID of the issuing task, a 2-bit operation code and one 32-bit data word. The first accepted operand load, or an accepted start, claims the unit for that task. The task then owns the unit until it has collected both halves of the 64-bit product. Any other task that touches the unit in that time gets a zero success flag, so its software can loop and retry.

Every request is answered in its own cycle. `respOk` acts as a carry-style success flag. `respRetry` tells the owner that the result is still being computed, so the read instruction should repeat and give its slot to the other tasks. `unitBusy` is a single status bit. It is high from the claiming step until the last result pickup, so a context-swap handler can wait for it to clear before it saves a task. Only one task issues per cycle, so the gate needs no arbitration between simultaneous requests.

Top module: `mul_gate`

## Requirements
- R1: A synchronous reset clears the owner, the busy bit, the result-valid state and the partial product. After reset, `unitBusy` is 0 and any read request gets `respOk`=0 and `respRetry`=0.
- R2: While the unit is unclaimed, an operand load (op 0) or a start (op 1) from any task gets `respOk`=1 in the same cycle, and `unitBusy` is 1 from the next cycle.
- R3: While the unit is claimed, every request from a task other than the owner gets `respOk`=0 and `respRetry`=0 and changes no state. In particular, the owner's product and its claim are unaffected.
- R4: A start may take two steps: a load of operand A (op 0), then a start carrying operand B (op 1). The first step already claims the unit, so a start from another task between the two steps is refused. A start from an unclaimed unit claims the unit in one step and uses the operand A held from the last accepted load.
- R5: The result is the unsigned 64-bit product A*B. A read of the low word (op 2) returns bits 31:0 and a read of the high word (op 3) returns bits 63:32, each with `respOk`=1. `respData` is 0 whenever `respOk` is 0.
- R6: After the owner's accepted start in cycle c, owner reads in cycles c+1 to c+32 get `respRetry`=1 and `respOk`=0. From cycle c+33 on, owner reads succeed. `respOk` and `respRetry` are never both 1.
- R7: The claim is released after the owner has read both result words, in either order. `unitBusy` falls in the cycle after the second of these reads. A read of only one word, repeated or not, keeps the claim.
- R8: `unitBusy` is 1 for the whole span from the claiming setup step, through the computation, to the final result pickup.
- R9: The owner's operand load or start is refused while a product is being computed or is waiting for pickup. An owner read before its start is refused with `respRetry`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | A task issues a request in this cycle |
| reqTask | input | 2 | ID of the issuing task |
| reqOp | input | 2 | 0 load A, 1 start with B, 2 read low word, 3 read high word |
| reqData | input | 32 | Operand word for op 0 and op 1 |
| respOk | output | 1 | Success flag for this cycle's request |
| respRetry | output | 1 | Owner read issued before the product is ready |
| respData | output | 32 | Requested product word when the read succeeds |
| unitBusy | output | 1 | Unit is claimed (setup, compute or pickup pending) |

## Verification
Two functions can fall in the same cycle: a shift-and-add step of the running multiplication, and a request from another task that tries to load or start the unit. The bench provokes this by issuing a foreign start in the very first compute cycle and a foreign read while the result waits for pickup. It judges the outcome by two things: the refusal in that cycle, and the product the owner later reads, which must still match the bench's own 64-bit multiplication. The same reasoning covers a one-word pickup followed by foreign and wrong-phase requests before the second word is read.

// File: rtl/mgate_pkg.sv
package mgate_pkg;
  typedef enum logic [1:0] {
    OP_LOADA = 2'd0,
    OP_GO    = 2'd1,
    OP_RDLO  = 2'd2,
    OP_RDHI  = 2'd3
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadA;
    logic start;
    logic step;
  } strobe_t;
endpackage

// File: rtl/mgate_dpath.sv
module mgate_dpath
  import mgate_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strb,
  input  logic [WIDTH-1:0] reqData,
  output logic [WIDTH-1:0] prodLo,
  output logic [WIDTH-1:0] prodHi
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] opA;
  logic [PW-1:0]    prod;
  logic [WIDTH:0]   sum;

  // one shift-and-add step: add A into the upper half when the multiplier bit is set
  always_comb begin
    sum = {1'b0, prod[PW-1:WIDTH]} + (prod[0] ? {1'b0, opA} : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opA  <= '0;
      prod <= '0;
    end else begin
      if (strb.loadA) opA <= reqData;
      if (strb.start)     prod <= {{WIDTH{1'b0}}, reqData};
      else if (strb.step) prod <= {sum, prod[WIDTH-1:1]};
    end
  end

  assign prodLo = prod[WIDTH-1:0];
  assign prodHi = prod[PW-1:WIDTH];
endmodule

// File: rtl/mgate_ctrl.sv
module mgate_ctrl
  import mgate_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int TID_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  input  logic [TID_W-1:0] reqTask,
  input  op_e              reqOp,
  output logic             respOk,
  output logic             respRetry,
  output logic             unitBusy,
  output logic [TID_W-1:0] ownerTag,
  output strobe_t          strb
);
  localparam int CNT_W = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_RUN, S_DONE} state_e;

  state_e           state, stateN;
  logic [TID_W-1:0] owner, ownerN;
  logic [CNT_W-1:0] cnt, cntN;
  logic             gotLo, gotHi, gotLoN, gotHiN;
  logic             mine, canStart, wantLo, wantHi;

  always_comb begin
    stateN    = state;
    ownerN    = owner;
    cntN      = cnt;
    gotLoN    = gotLo;
    gotHiN    = gotHi;
    strb      = '0;
    respOk    = 1'b0;
    respRetry = 1'b0;
    mine      = (state != S_IDLE) && (reqTask == owner);
    canStart  = (state == S_IDLE) || ((state == S_SETUP) && mine);
    wantLo    = (reqOp == OP_RDLO);
    wantHi    = (reqOp == OP_RDHI);

    if (state == S_RUN) begin
      strb.step = 1'b1;
      cntN      = cnt + 1'b1;
      if (cnt == LAST_STEP) begin
        stateN = S_DONE;
        gotLoN = 1'b0;
        gotHiN = 1'b0;
      end
    end

    if (reqValid) begin
      unique case (reqOp)
        OP_LOADA: if (canStart) begin
          respOk     = 1'b1;
          strb.loadA = 1'b1;
          ownerN     = reqTask;
          stateN     = S_SETUP;
        end
        OP_GO: if (canStart) begin
          respOk     = 1'b1;
          strb.start = 1'b1;
          ownerN     = reqTask;
          stateN     = S_RUN;
          cntN       = '0;
        end
        OP_RDLO, OP_RDHI: if (mine) begin
          if (state == S_RUN) begin
            respRetry = 1'b1;
          end else if (state == S_DONE) begin
            respOk = 1'b1;
            if (wantLo) gotLoN = 1'b1;
            if (wantHi) gotHiN = 1'b1;
            if ((wantLo || gotLo) && (wantHi || gotHi)) stateN = S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      owner <= '0;
      cnt   <= '0;
      gotLo <= 1'b0;
      gotHi <= 1'b0;
    end else begin
      state <= stateN;
      owner <= ownerN;
      cnt   <= cntN;
      gotLo <= gotLoN;
      gotHi <= gotHiN;
    end
  end

  assign unitBusy = (state != S_IDLE);
  assign ownerTag = owner;
endmodule

// File: rtl/mul_gate.sv
module mul_gate
  import mgate_pkg::*;
#(
  parameter int TASKS = 4,
  parameter int WIDTH = 32,
  localparam int TID_W = $clog2(TASKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  input  logic [TID_W-1:0] reqTask,
  input  logic [1:0]       reqOp,
  input  logic [WIDTH-1:0] reqData,
  output logic             respOk,
  output logic             respRetry,
  output logic [WIDTH-1:0] respData,
  output logic             unitBusy
);
  strobe_t          strb;
  logic [WIDTH-1:0] prodLo, prodHi;
  logic [TID_W-1:0] ownerTag;
  op_e              opCode;

  assign opCode = op_e'(reqOp);

  mgate_ctrl #(.WIDTH(WIDTH), .TID_W(TID_W)) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqTask(reqTask), .reqOp(opCode),
    .respOk(respOk), .respRetry(respRetry), .unitBusy(unitBusy),
    .ownerTag(ownerTag), .strb(strb)
  );

  mgate_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .reqData(reqData),
    .prodLo(prodLo), .prodHi(prodHi)
  );

  always_comb begin
    respData = '0;
    if (respOk && reqOp[1]) respData = (opCode == OP_RDHI) ? prodHi : prodLo;
  end
endmodule

// File: rtl/mgate_checker.sv
module mgate_checker #(
  parameter int TID_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             reqValid,
  input logic [TID_W-1:0] reqTask,
  input logic [1:0]       reqOp,
  input logic             respOk,
  input logic             respRetry,
  input logic             unitBusy,
  input logic [TID_W-1:0] ownerTag
);
  assert_resp_excl_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({respOk, respRetry}));

  assert_claim_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqOp[1] && respOk) |=> unitBusy);

  assert_foreign_refused_R3: assert property (@(posedge clk) disable iff (rst)
    (reqValid && unitBusy && (reqTask != ownerTag)) |-> (!respOk && !respRetry));

  assert_owner_hold_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(unitBusy) && unitBusy) |-> $stable(ownerTag));

  assert_retry_busy_R6: assert property (@(posedge clk) disable iff (rst)
    respRetry |-> unitBusy);

  assert_idle_read_R1: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqOp[1] && !unitBusy) |-> !respOk);

  assert_release_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(unitBusy) |-> $past(reqValid && reqOp[1] && respOk));
endmodule

bind mul_gate mgate_checker #(.TID_W(TID_W)) u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqTask(reqTask), .reqOp(reqOp),
  .respOk(respOk), .respRetry(respRetry), .unitBusy(unitBusy), .ownerTag(ownerTag)
);

// File: tb/sim_mul_gate.sv
module sim_mul_gate;
  localparam logic [1:0] LDA = 2'd0, GO = 2'd1, RLO = 2'd2, RHI = 2'd3;

  logic        clk = 1'b0, rst = 1'b1, reqValid = 1'b0;
  logic [1:0]  reqTask = '0, reqOp = '0;
  logic [31:0] reqData = '0;
  logic        respOk, respRetry, unitBusy;
  logic [31:0] respData;

  mul_gate u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqTask(reqTask), .reqOp(reqOp),
    .reqData(reqData), .respOk(respOk), .respRetry(respRetry),
    .respData(respData), .unitBusy(unitBusy)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    logic        ok;
    logic        retry;
    logic        chkData;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  int   nChecks = 0, nFails = 0;
  bit   finished = 1'b0;

  // driver: one request per call, expectation pushed to scoreboard
  task automatic issue(input logic [1:0] t, input logic [1:0] op, input logic [31:0] d,
                       input logic eOk, input logic eRetry, input logic [31:0] eData,
                       input string tag);
    exp_t e;
    @(negedge clk);
    reqValid = 1'b1; reqTask = t; reqOp = op; reqData = d;
    e.ok = eOk; e.retry = eRetry; e.chkData = 1'b1;
    e.data = (eOk && op[1]) ? eData : 32'h0;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic checkBusy(input logic expB, input string tag);
    @(negedge clk);
    reqValid = 1'b0;
    #5;
    nChecks++;
    if (unitBusy !== expB) begin
      nFails++;
      $display("FAIL %s unitBusy actual=%0b expected=%0b", tag, unitBusy, expB);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    reqValid = 1'b0; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // full claim/compute/pickup sequence by one task
  task automatic runMul(input logic [1:0] t, input logic [31:0] a, input logic [31:0] b,
                        input bit loFirst);
    logic [63:0] p;
    p = {32'h0, a} * {32'h0, b};
    issue(t, LDA, a, 1, 0, 0, "R2");
    issue(t, GO, b, 1, 0, 0, "R4");
    repeat (32) issue(t, RLO, 0, 0, 1, 0, "R6");
    if (loFirst) begin
      issue(t, RLO, 0, 1, 0, p[31:0], "R5");
      checkBusy(1'b1, "R7");
      issue(t, RHI, 0, 1, 0, p[63:32], "R5");
    end else begin
      issue(t, RHI, 0, 1, 0, p[63:32], "R5");
      checkBusy(1'b1, "R7");
      issue(t, RLO, 0, 1, 0, p[31:0], "R5");
    end
    checkBusy(1'b0, "R7");
  endtask

  // monitor: pops scoreboard and compares mid-cycle
  always @(negedge clk) begin
    #5;
    if (reqValid && !rst) begin
      exp_t e;
      nChecks++;
      if (expQ.size() == 0) begin
        nFails++;
        $display("FAIL scoreboard underflow actual=empty expected=item");
      end else begin
        e = expQ.pop_front();
        if (respOk !== e.ok || respRetry !== e.retry || (e.chkData && respData !== e.data)) begin
          nFails++;
          $display("FAIL %s ok/retry/data actual=%0b/%0b/%h expected=%0b/%0b/%h",
                   e.tag, respOk, respRetry, respData, e.ok, e.retry, e.data);
        end
      end
    end
  end

  initial begin : watchdog
    #(20 * 200000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stimulus
    logic [63:0] p;
    doReset();
    // R1: idle after reset, reads refused
    checkBusy(1'b0, "R1");
    issue(0, RLO, 0, 0, 0, 0, "R1");
    issue(2, RHI, 0, 0, 0, 0, "R1");

    // two-step start with interference
    p = 64'h1234_5678 * 64'h9abc_def0;
    issue(1, LDA, 32'h1234_5678, 1, 0, 0, "R2");
    checkBusy(1'b1, "R8");                          // busy during setup phase
    issue(2, LDA, 32'h5555_5555, 0, 0, 0, "R3");
    issue(2, GO, 32'h0000_0003, 0, 0, 0, "R4");     // refused between two steps
    issue(1, RLO, 0, 0, 0, 0, "R9");                // read before start: refused, no retry
    issue(1, GO, 32'h9abc_def0, 1, 0, 0, "R4");
    issue(3, GO, 32'h0000_0005, 0, 0, 0, "R3");     // foreign start during first compute step
    repeat (31) issue(1, RLO, 0, 0, 1, 0, "R6");
    issue(1, RHI, 0, 1, 0, p[63:32], "R5");         // first ready cycle c+33
    checkBusy(1'b1, "R7");                          // high alone keeps claim
    issue(1, GO, 32'h7, 0, 0, 0, "R9");
    issue(1, LDA, 32'h7, 0, 0, 0, "R9");
    issue(0, RLO, 0, 0, 0, 0, "R3");
    issue(1, RHI, 0, 1, 0, p[63:32], "R7");         // repeat high still keeps claim
    checkBusy(1'b1, "R8");
    issue(1, RLO, 0, 1, 0, p[31:0], "R5");
    checkBusy(1'b0, "R7");

    // more operand patterns, both pickup orders
    runMul(2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    runMul(0, 32'h0000_0007, 32'h0000_0003, 1'b0);

    // R4: single-step start reuses last loaded A (7)
    issue(3, GO, 32'h0000_0006, 1, 0, 0, "R4");
    repeat (32) issue(3, RLO, 0, 0, 1, 0, "R6");
    issue(3, RLO, 0, 1, 0, 32'd42, "R4");
    issue(3, RHI, 0, 1, 0, 32'd0, "R4");
    checkBusy(1'b0, "R7");

    runMul(1, 32'h0000_0000, 32'hDEAD_BEEF, 1'b1);
    runMul(3, 32'h8000_0001, 32'h0000_0002, 1'b0);

    // R1: reset during computation
    issue(1, LDA, 32'h3, 1, 0, 0, "R2");
    issue(1, GO, 32'h4, 1, 0, 0, "R4");
    doReset();
    checkBusy(1'b0, "R1");
    issue(1, RLO, 0, 0, 0, 0, "R1");
    runMul(2, 32'h0001_0000, 32'h0001_0000, 1'b1);

    checkBusy(1'b0, "R8");
    nChecks++;
    if (expQ.size() != 0) begin
      nFails++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", expQ.size());
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule